// File: doc/BRIEF.md
# Video Input Front-End Decoder with Sample Limiter

This block sits at the entry of a video encoder. It takes 10-bit digital video in one of three forms and delivers 4:4:4 pixels, a sample-valid pulse and active-high sync flags to the stages after it. The forms are:

- a single multiplexed 4:2:2 word stream with embedded timing codes;
- separate luma and chroma buses carrying 4:2:2 or 4:1:1 data, with timing on sync pins;
- three full-rate 4:4:4 buses (RGB or YCbCr) that need no format change.

In the embedded-timing form, the block finds the three-word preamble ahead of each timing reference word. It checks the word's protection bits and keeps field, vertical and horizontal flags from every code that passes the check. A start-of-active-video code starts demultiplexing of the stream. Each chroma pair is repeated across the pixels it covers.

A final limiter clamps every output sample to a standard range or to a wider range. The input clock runs at twice the pixel rate, and the block divides it by two to make its own pixel strobe.

Top module: `vdec_front`

## Requirements
- R1: `pix_stb_o` is 0 in reset and toggles on every clock edge after reset. In split and full modes, inputs are taken on edges where `pix_stb_o` is 1.
- R2: Embedded mode (`fmt_i`=0) watches for the preamble 3FF, 000, 000. The word after it is a timing reference: bit 8 sets `fld_o`, bit 7 sets `vs_o` and bit 6 sets `hs_o` from the next cycle on. H=1 marks the end of active video and H=0 marks the start. `blank_o` is `vs_o` OR `hs_o`.
- R3: A timing reference is accepted only when bit 9 is 1 and bits 5..2 equal V^H, F^H, F^V and F^V^H. If the check fails, all flags stay as they were and a failing start code does not start active video.
- R4: After an accepted start code, the stream word order is Cb, Y, Cr, Y. The pixels come out in order as (Y0,Cb,Cr) and then (Y1,Cb,Cr). A word 3FF ends active video and releases the last pending pixel.
- R5: In split mode (`fmt_i`=1, `sub411_i`=0), the chroma bus carries Cb on the first active pixel after blanking (`blank_ni` low) and Cr on the next one, and this repeats. Each pair is applied to both pixels. Output appears one pixel late, and the first blanked strobe releases the last pixel.
- R6: In split mode with `sub411_i`=1, the chroma bus carries Cb and then Cr, followed by two words that are ignored. The pair is applied to all four pixels.
- R7: In full mode (`fmt_i`=2 or 3), each strobe with `blank_ni` high emits one pixel with `y_o`=`dat_y_i`, `cb_o`=`dat_b_i` and `cr_o`=`dat_c_i`, with no format change.
- R8: With `ext_range_i`=0, every output sample is clamped to the range 64 to 940.
- R9: With `ext_range_i`=1, every output sample is clamped to the range 4 to 1016.
- R10: In split and full modes, `hs_o`, `vs_o` and `blank_o` are the inverted sync pins, registered by one clock, and `fld_o` is 0.
- R11: During reset, `valid_o`, all sample outputs and all sync outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 2 | 0 embedded multiplexed, 1 split luma/chroma, 2/3 full 4:4:4 |
| sub411_i | input | 1 | Split mode: 1 selects 4:1:1 chroma |
| ext_range_i | input | 1 | 1 selects the extended limiter range |
| dat_y_i | input | W | Luma / green bus, also the multiplexed stream |
| dat_c_i | input | W | Chroma / Cr / red bus |
| dat_b_i | input | W | Cb / blue bus (full mode) |
| hsync_ni | input | 1 | Horizontal sync pin, active low |
| vsync_ni | input | 1 | Vertical sync pin, active low |
| blank_ni | input | 1 | Blanking pin, active low (high = active pixels) |
| pix_stb_o | output | 1 | Pixel-rate strobe |
| valid_o | output | 1 | One-clock pulse per output pixel |
| y_o | output | W | Luma / green sample |
| cb_o | output | W | Cb / blue sample |
| cr_o | output | W | Cr / red sample |
| hs_o | output | 1 | Horizontal blanking flag |
| vs_o | output | 1 | Vertical blanking flag |
| blank_o | output | 1 | Combined blanking flag |
| fld_o | output | 1 | Field flag |

## Verification
The bench builds the block with its default parameters: 10-bit words, a standard range of 64 to 940 and an extended range of 4 to 1016. With 10-bit words, the preamble values 3FF and 000 and the protection bits at positions 9 to 2 can be driven exactly. The extreme inputs 0 and 1023 can be applied to test every clamp edge in both ranges. Chroma values just above 940 in the embedded stream show that the limiter acts on demultiplexed chroma, not only on luma.

// File: rtl/vdec_pkg.sv
`timescale 1ns/1ps
package vdec_pkg;
   typedef enum logic [1:0] {
      FMT_EMBED = 2'd0,
      FMT_SPLIT = 2'd1,
      FMT_FULL  = 2'd2,
      FMT_WIDE  = 2'd3
   } fmt_e;
endpackage

// File: rtl/vdec_trs.sv
`timescale 1ns/1ps
// Timing-reference finder and multiplexed-stream demultiplexer.
module vdec_trs #(
   parameter int W = 10
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         en_i,
   input  logic [W-1:0] word_i,
   output logic         fld_o,
   output logic         vert_o,
   output logic         horz_o,
   output logic         step_o,
   output logic         sval_o,
   output logic [W-1:0] sy_o,
   output logic [W-1:0] sc_o
);
   localparam logic [W-1:0] ALL1 = {W{1'b1}};
   localparam int BF  = W - 2;
   localparam int BV  = W - 3;
   localparam int BH  = W - 4;
   localparam int BP3 = W - 5;
   localparam int BP2 = W - 6;
   localparam int BP1 = W - 7;
   localparam int BP0 = W - 8;

   logic [W-1:0] d1_q, d2_q, d3_q, hold_q;
   logic         act_q;
   logic [1:0]   ph_q;
   logic         pre, prot_ok, code_ok, is_top, sav;
   logic         xf, xv, xh;

   always_comb begin
      xf      = word_i[BF];
      xv      = word_i[BV];
      xh      = word_i[BH];
      pre     = (d3_q == ALL1) && (d2_q == '0) && (d1_q == '0);
      prot_ok = word_i[W-1] && (word_i[BP3] == (xv ^ xh)) && (word_i[BP2] == (xf ^ xh)) &&
                (word_i[BP1] == (xf ^ xv)) && (word_i[BP0] == (xf ^ xv ^ xh));
      code_ok = en_i && pre && prot_ok;
      is_top  = (word_i == ALL1);
      sav     = code_ok && !xh;
      step_o  = en_i && act_q && (is_top || ph_q[0]);
      sval_o  = !is_top;
      sy_o    = word_i;
      sc_o    = hold_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         d1_q   <= '0;
         d2_q   <= '0;
         d3_q   <= '0;
         hold_q <= '0;
         act_q  <= 1'b0;
         ph_q   <= 2'd0;
         fld_o  <= 1'b0;
         vert_o <= 1'b0;
         horz_o <= 1'b0;
      end else if (!en_i) begin
         act_q <= 1'b0;
      end else begin
         d3_q <= d2_q;
         d2_q <= d1_q;
         d1_q <= word_i;
         if (code_ok) begin
            fld_o  <= xf;
            vert_o <= xv;
            horz_o <= xh;
         end
         if (is_top) begin
            act_q <= 1'b0;
         end else if (sav) begin
            act_q <= 1'b1;
            ph_q  <= 2'd0;
         end else if (act_q) begin
            ph_q <= ph_q + 2'd1;
            if (!ph_q[0]) hold_q <= word_i;
         end
      end
   end
endmodule

// File: rtl/vdec_upsamp.sv
`timescale 1ns/1ps
// Repeats each chroma pair over its group of 2 or 4 pixels, one pixel late.
module vdec_upsamp #(
   parameter int W = 10
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         step_i,
   input  logic         val_i,
   input  logic         quad_i,
   input  logic [W-1:0] y_i,
   input  logic [W-1:0] c_i,
   output logic         pv_o,
   output logic [W-1:0] py_o,
   output logic [W-1:0] pcb_o,
   output logic [W-1:0] pcr_o
);
   logic         slot_v;
   logic [W-1:0] slot_y, cb_new, pair_cb, pair_cr;
   logic [1:0]   slot_p, p_q, last;

   always_comb begin
      last  = quad_i ? 2'd3 : 2'd1;
      pv_o  = step_i && slot_v;
      py_o  = slot_y;
      pcb_o = (slot_p == 2'd0) ? cb_new : pair_cb;
      pcr_o = (slot_p == 2'd0) ? c_i    : pair_cr;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         slot_v  <= 1'b0;
         slot_y  <= '0;
         slot_p  <= 2'd0;
         p_q     <= 2'd0;
         cb_new  <= '0;
         pair_cb <= '0;
         pair_cr <= '0;
      end else if (step_i) begin
         slot_v <= val_i;
         slot_y <= y_i;
         slot_p <= p_q;
         if (val_i) begin
            if (p_q == 2'd0) cb_new <= c_i;
            if (p_q == 2'd1) begin
               pair_cb <= cb_new;
               pair_cr <= c_i;
            end
            p_q <= (p_q == last) ? 2'd0 : p_q + 2'd1;
         end else begin
            p_q <= 2'd0;
         end
      end
   end
endmodule

// File: rtl/vdec_clip.sv
`timescale 1ns/1ps
// Two-range sample clamp.
module vdec_clip #(
   parameter int W      = 10,
   parameter int LO_STD = 64,
   parameter int HI_STD = 940,
   parameter int LO_EXT = 4,
   parameter int HI_EXT = 1016
) (
   input  logic         ext_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   localparam logic [W-1:0] LS = W'(LO_STD);
   localparam logic [W-1:0] HS = W'(HI_STD);
   localparam logic [W-1:0] LE = W'(LO_EXT);
   localparam logic [W-1:0] HE = W'(HI_EXT);

   logic [W-1:0] lo, hi;

   always_comb begin
      lo = ext_i ? LE : LS;
      hi = ext_i ? HE : HS;
      if (d_i < lo)      q_o = lo;
      else if (d_i > hi) q_o = hi;
      else               q_o = d_i;
   end
endmodule

// File: rtl/vdec_front.sv
`timescale 1ns/1ps
module vdec_front
   import vdec_pkg::*;
#(
   parameter int W      = 10,
   parameter int LO_STD = 64,
   parameter int HI_STD = 940,
   parameter int LO_EXT = 4,
   parameter int HI_EXT = 1016
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [1:0]   fmt_i,
   input  logic         sub411_i,
   input  logic         ext_range_i,
   input  logic [W-1:0] dat_y_i,
   input  logic [W-1:0] dat_c_i,
   input  logic [W-1:0] dat_b_i,
   input  logic         hsync_ni,
   input  logic         vsync_ni,
   input  logic         blank_ni,
   output logic         pix_stb_o,
   output logic         valid_o,
   output logic [W-1:0] y_o,
   output logic [W-1:0] cb_o,
   output logic [W-1:0] cr_o,
   output logic         hs_o,
   output logic         vs_o,
   output logic         blank_o,
   output logic         fld_o
);
   localparam int NCH  = 3;
   localparam int VMAX = (1 << W) - 1;

   if (W < 8) begin : g_bad_width
      $error("vdec_front: W must be at least 8");
   end
   if (LO_STD > HI_STD || LO_EXT > HI_EXT) begin : g_bad_order
      $error("vdec_front: limiter low bound above high bound");
   end
   if (HI_STD > VMAX || HI_EXT > VMAX) begin : g_bad_range
      $error("vdec_front: limiter bound exceeds word range");
   end

   fmt_e fmt;
   assign fmt = fmt_e'(fmt_i);

   logic pix_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pix_q <= 1'b0;
      else         pix_q <= ~pix_q;
   end

   logic         t_f, t_v, t_h, t_step, t_val;
   logic [W-1:0] t_y, t_c;

   vdec_trs #(.W(W)) u_trs (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (fmt == FMT_EMBED),
      .word_i (dat_y_i),
      .fld_o  (t_f),
      .vert_o (t_v),
      .horz_o (t_h),
      .step_o (t_step),
      .sval_o (t_val),
      .sy_o   (t_y),
      .sc_o   (t_c)
   );

   logic         u_step, u_val, u_quad, u_pv;
   logic [W-1:0] u_y, u_c, u_py, u_pcb, u_pcr;

   always_comb begin
      u_step = 1'b0;
      u_val  = 1'b0;
      u_quad = 1'b0;
      u_y    = '0;
      u_c    = '0;
      if (fmt == FMT_EMBED) begin
         u_step = t_step;
         u_val  = t_val;
         u_y    = t_y;
         u_c    = t_c;
      end else if (fmt == FMT_SPLIT) begin
         u_step = pix_q;
         u_val  = blank_ni;
         u_quad = sub411_i;
         u_y    = dat_y_i;
         u_c    = dat_c_i;
      end
   end

   vdec_upsamp #(.W(W)) u_ups (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (u_step),
      .val_i  (u_val),
      .quad_i (u_quad),
      .y_i    (u_y),
      .c_i    (u_c),
      .pv_o   (u_pv),
      .py_o   (u_py),
      .pcb_o  (u_pcb),
      .pcr_o  (u_pcr)
   );

   logic         r_pv;
   logic [W-1:0] raw [NCH];
   logic [W-1:0] clp [NCH];

   always_comb begin
      if (fmt == FMT_FULL || fmt == FMT_WIDE) begin
         r_pv   = pix_q && blank_ni;
         raw[0] = dat_y_i;
         raw[1] = dat_b_i;
         raw[2] = dat_c_i;
      end else begin
         r_pv   = u_pv;
         raw[0] = u_py;
         raw[1] = u_pcb;
         raw[2] = u_pcr;
      end
   end

   for (genvar k = 0; k < NCH; k++) begin : g_clip
      vdec_clip #(
         .W(W), .LO_STD(LO_STD), .HI_STD(HI_STD), .LO_EXT(LO_EXT), .HI_EXT(HI_EXT)
      ) u_clip (
         .ext_i (ext_range_i),
         .d_i   (raw[k]),
         .q_o   (clp[k])
      );
   end

   logic         pin_h, pin_v, pin_b;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_o <= 1'b0;
         y_o     <= '0;
         cb_o    <= '0;
         cr_o    <= '0;
         pin_h   <= 1'b0;
         pin_v   <= 1'b0;
         pin_b   <= 1'b0;
      end else begin
         valid_o <= r_pv;
         if (r_pv) begin
            y_o  <= clp[0];
            cb_o <= clp[1];
            cr_o <= clp[2];
         end
         pin_h <= ~hsync_ni;
         pin_v <= ~vsync_ni;
         pin_b <= ~blank_ni;
      end
   end

   always_comb begin
      pix_stb_o = pix_q;
      if (fmt == FMT_EMBED) begin
         hs_o    = t_h;
         vs_o    = t_v;
         blank_o = t_h | t_v;
         fld_o   = t_f;
      end else begin
         hs_o    = pin_h;
         vs_o    = pin_v;
         blank_o = pin_b;
         fld_o   = 1'b0;
      end
   end
endmodule

// File: rtl/vdec_front_chk.sv
`timescale 1ns/1ps
module vdec_front_chk #(
   parameter int W      = 10,
   parameter int LO_STD = 64,
   parameter int HI_STD = 940,
   parameter int LO_EXT = 4,
   parameter int HI_EXT = 1016
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic [1:0]   fmt_i,
   input logic         ext_range_i,
   input logic         pix_stb_o,
   input logic         valid_o,
   input logic [W-1:0] y_o,
   input logic [W-1:0] cb_o,
   input logic [W-1:0] cr_o
);
   localparam logic [W-1:0] LS = W'(LO_STD);
   localparam logic [W-1:0] HS = W'(HI_STD);
   localparam logic [W-1:0] LE = W'(LO_EXT);
   localparam logic [W-1:0] HE = W'(HI_EXT);

   a_r1_strobe_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pix_stb_o |=> pix_stb_o);

   a_r1_strobe_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pix_stb_o |=> !pix_stb_o);

   a_r9_ext_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (y_o >= LE && y_o <= HE && cb_o >= LE && cb_o <= HE &&
                   cr_o >= LE && cr_o <= HE));

   a_r8_std_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !$past(ext_range_i)) |->
         (y_o >= LS && y_o <= HS && cb_o >= LS && cb_o <= HS && cr_o >= LS && cr_o <= HS));

   a_r5_one_pixel_per_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fmt_i != 2'd0 && $past(fmt_i) != 2'd0 && valid_o) |=> !valid_o);
endmodule

bind vdec_front vdec_front_chk #(
   .W(W), .LO_STD(LO_STD), .HI_STD(HI_STD), .LO_EXT(LO_EXT), .HI_EXT(HI_EXT)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .fmt_i       (fmt_i),
   .ext_range_i (ext_range_i),
   .pix_stb_o   (pix_stb_o),
   .valid_o     (valid_o),
   .y_o         (y_o),
   .cb_o        (cb_o),
   .cr_o        (cr_o)
);

// File: tb/tb_vdec_front.sv
`timescale 1ns/1ps
module tb_vdec_front;
   localparam int W = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   fmt = 2'd0;
   logic         sub411 = 1'b0, ext = 1'b0;
   logic [W-1:0] dy = '0, dc = '0, db = '0;
   logic         hs_n = 1'b1, vs_n = 1'b1, bl_n = 1'b0;
   logic         pix, vld, hs, vs, bl, fld;
   logic [W-1:0] y, cb, cr;

   vdec_front dut (
      .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .sub411_i(sub411), .ext_range_i(ext),
      .dat_y_i(dy), .dat_c_i(dc), .dat_b_i(db), .hsync_ni(hs_n), .vsync_ni(vs_n),
      .blank_ni(bl_n), .pix_stb_o(pix), .valid_o(vld), .y_o(y), .cb_o(cb), .cr_o(cr),
      .hs_o(hs), .vs_o(vs), .blank_o(bl), .fld_o(fld)
   );

   always #4 clk = ~clk;

   // Embedded stream: SAV (F0 V0), two Cb/Y/Cr/Y groups, EAV (F0 V0).
   localparam int NW = 16;
   localparam logic [W-1:0] EMB [0:NW-1] = '{
      10'h3FF, 10'h000, 10'h000, 10'h200,
      10'h040, 10'h100, 10'h3C0, 10'h120,
      10'h050, 10'h140, 10'h200, 10'h160,
      10'h3FF, 10'h000, 10'h000, 10'h274 };
   // Expected {Y, Cb, Cr}; Cr 3C0 clamps to 940 (3AC) in the standard range (R8).
   localparam logic [3*W-1:0] EMB_EXP [0:3] = '{
      {10'h100, 10'h040, 10'h3AC}, {10'h120, 10'h040, 10'h3AC},
      {10'h140, 10'h050, 10'h200}, {10'h160, 10'h050, 10'h200} };

   int n_chk = 0, n_bad = 0;
   logic [W-1:0] ey [0:63], ecb [0:63], ecr [0:63];
   string        etag [0:63];
   int           e_wr = 0, e_rd = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic expect_px(input string req, input logic [W-1:0] a, b, c);
      ey[e_wr] = a; ecb[e_wr] = b; ecr[e_wr] = c; etag[e_wr] = req;
      e_wr++;
   endtask

   always @(negedge clk) begin
      if (rst_n && vld) begin
         n_chk++;
         if (e_rd >= e_wr) begin
            n_bad++;
            $display("FAIL R4 unexpected pixel actual=%0h/%0h/%0h expected=none", y, cb, cr);
         end else begin
            if (y !== ey[e_rd] || cb !== ecb[e_rd] || cr !== ecr[e_rd]) begin
               n_bad++;
               $display("FAIL %s actual=%0h/%0h/%0h expected=%0h/%0h/%0h", etag[e_rd],
                        y, cb, cr, ey[e_rd], ecb[e_rd], ecr[e_rd]);
            end
            e_rd++;
         end
      end
   end

   task automatic do_reset(input logic [1:0] f);
      @(negedge clk);
      rst_n = 1'b0; fmt = f; dy = '0; dc = '0; db = '0; bl_n = 1'b0;
      e_wr = 0; e_rd = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic put_word(input logic [W-1:0] w);
      @(negedge clk);
      dy = w;
   endtask

   task automatic put_pixel(input logic [W-1:0] a, c, b, input logic bn);
      @(negedge clk);
      while (!pix) @(negedge clk);
      dy = a; dc = c; db = b; bl_n = bn;
   endtask

   task automatic preamble(input logic [W-1:0] code);
      put_word(10'h3FF); put_word(10'h000); put_word(10'h000); put_word(code);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=timeout expected=finished");
      summary();
      $finish;
   end

   initial begin
      // R11: reset state
      repeat (2) @(negedge clk);
      check("R11 valid", vld, 0);
      check("R11 samples", {y, cb, cr}, 0);
      check("R11 sync", {hs, vs, bl, fld}, 0);
      check("R1 strobe in reset", pix, 0);
      rst_n = 1'b1;
      @(negedge clk); check("R1 strobe first", pix, 1);
      @(negedge clk); check("R1 strobe second", pix, 0);

      // Embedded mode: table walk
      do_reset(2'd0);
      for (int i = 0; i < 4; i++)
         expect_px("R4", EMB_EXP[i][3*W-1:2*W], EMB_EXP[i][2*W-1:W], EMB_EXP[i][W-1:0]);
      for (int i = 0; i < NW; i++) put_word(EMB[i]);
      @(negedge clk);
      check("R2 eav flags h/v/f", {hs, vs, fld}, 3'b100);
      check("R2 blank", bl, 1);
      check("R4 all pixels seen", e_rd, 4);

      // R2: EAV with F=1 V=1
      preamble(10'h3C4);
      @(negedge clk);
      check("R2 vertical flags h/v/f", {hs, vs, fld}, 3'b111);

      // R3: corrupted SAV (P0 flipped) is ignored
      preamble(10'h3B4);
      put_word(10'h060); put_word(10'h300); put_word(10'h0A0); put_word(10'h310);
      @(negedge clk);
      check("R3 flags kept", {hs, vs, fld}, 3'b111);
      check("R3 no video", e_rd, e_wr);

      // R4: good SAV (F1 V1) then one group and an end word
      expect_px("R4", 10'h300, 10'h060, 10'h0A0);
      expect_px("R4", 10'h310, 10'h060, 10'h0A0);
      preamble(10'h3B0);
      put_word(10'h060); put_word(10'h300); put_word(10'h0A0); put_word(10'h310);
      put_word(10'h3FF);
      put_word(10'h000);
      @(negedge clk);
      check("R2 sav flags h/v/f", {hs, vs, fld}, 3'b011);
      check("R2 blank vert", bl, 1);
      check("R4 flushed", e_rd, 6);

      // Split 4:2:2 with sync pins
      do_reset(2'd1);
      hs_n = 1'b0; vs_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R10 sync pins h/v/b/f", {hs, vs, bl, fld}, 4'b1010);
      hs_n = 1'b1;
      expect_px("R5", 10'h200, 10'h100, 10'h300);
      expect_px("R5", 10'h210, 10'h100, 10'h300);
      expect_px("R5", 10'h220, 10'h180, 10'h280);
      expect_px("R5", 10'h230, 10'h180, 10'h280);
      put_pixel(10'h200, 10'h100, 10'h000, 1'b1);
      put_pixel(10'h210, 10'h300, 10'h000, 1'b1);
      put_pixel(10'h220, 10'h180, 10'h000, 1'b1);
      put_pixel(10'h230, 10'h280, 10'h000, 1'b1);
      put_pixel(10'h000, 10'h000, 10'h000, 1'b0);
      repeat (3) @(negedge clk);
      check("R5 all pixels seen", e_rd, 4);
      check("R10 sync pins idle", {hs, vs, bl, fld}, 4'b0010);

      // Split 4:1:1: third and fourth chroma words are extreme and ignored
      do_reset(2'd1);
      sub411 = 1'b1;
      for (int i = 0; i < 4; i++) expect_px("R6", 10'(10'h240 + 16 * i), 10'h120, 10'h2E0);
      put_pixel(10'h240, 10'h120, 10'h000, 1'b1);
      put_pixel(10'h250, 10'h2E0, 10'h000, 1'b1);
      put_pixel(10'h260, 10'h3FF, 10'h000, 1'b1);
      put_pixel(10'h270, 10'h000, 10'h000, 1'b1);
      put_pixel(10'h000, 10'h000, 10'h000, 1'b0);
      repeat (3) @(negedge clk);
      check("R6 all pixels seen", e_rd, 4);
      sub411 = 1'b0;

      // Full 4:4:4 passthrough and both limiter ranges
      do_reset(2'd2);
      expect_px("R7", 10'h1F4, 10'h0C8, 10'h12C);
      expect_px("R8", 10'd64, 10'd500, 10'd940);
      put_pixel(10'h1F4, 10'h12C, 10'h0C8, 1'b1);
      put_pixel(10'd0, 10'd1023, 10'd500, 1'b1);
      put_pixel(10'd0, 10'd0, 10'd0, 1'b0);
      repeat (3) @(negedge clk);
      check("R8 std pixels seen", e_rd, 2);
      ext = 1'b1;
      expect_px("R9", 10'd4, 10'd4, 10'd1016);
      expect_px("R9", 10'd1010, 10'd600, 10'd10);
      put_pixel(10'd0, 10'd1023, 10'd2, 1'b1);
      put_pixel(10'd1010, 10'd10, 10'd600, 1'b1);
      put_pixel(10'd0, 10'd0, 10'd0, 1'b0);
      repeat (3) @(negedge clk);
      check("R9 ext pixels seen", e_rd, 4);
      check("R10 full mode field", fld, 0);

      summary();
      $finish;
   end
endmodule